// File: doc/BRIEF.md
# Branch and Skip Decision Unit

This block sits beside the program counter of a small 8-bit processor core. On each valid request it receives the class of the instruction being retired, the current program counter, the status byte, an operand pair or a data byte with a bit selector, the raw offset field, the 16-bit Z pointer and a flag that says whether the following instruction is one word or two. It decides whether control flow leaves the sequential path, produces the program counter to fetch next, and reports how many cycles the instruction costs.

It covers conditional branches on any single status bit in either polarity, including the signed greater-or-equal and less-than tests, relative and indirect jumps and calls, returns, and the skip family: compare-and-skip-if-equal and skip-on-bit for a register or I/O byte. A skip jumps over the next instruction, so its distance and cost depend on that instruction's length. The stack traffic of calls and returns happens elsewhere. For those instructions only the cycle cost is produced here. The decision is registered, so results appear one clock after the request.

Top module: `bsu_core`

## Requirements
- R1: While reset is asserted and until the first valid request, out_valid_o, taken_o, next_pc_o and cycles_o are all zero.
- R2: op_i = 1 is a status branch. Status bit positions are C=0, Z=1, N=2, V=3, S=4, H=5, T=6, I=7. The branch is taken when sreg_i[sel_i] equals pol_i (1 = branch if set, 0 = branch if clear). Taken: next_pc_o = pc_i + sext(offset_i[6:0]) + 1, cycles_o = 2, taken_o = 1. Not taken: pc_i + 1, 1 cycle, taken_o = 0. offset_i[11:7] have no effect on a branch.
- R3: For a status branch with sel_i = 4, the tested value is sreg_i[2] XOR sreg_i[3], and the stored sreg_i[4] is ignored. pol_i = 0 gives signed greater-or-equal and pol_i = 1 gives signed less-than.
- R4: op_i = 2 (relative jump) and op_i = 4 (relative call) give next_pc_o = pc_i + sext(offset_i[11:0]) + 1 with taken_o = 1. The jump costs 2 cycles and the call costs 3. All PC arithmetic wraps modulo 2^16.
- R5: op_i = 3 (indirect jump) and op_i = 5 (indirect call) load next_pc_o from zptr_i with taken_o = 1. The jump costs 2 cycles and the call costs 3.
- R6: op_i = 6 (return) and op_i = 7 (interrupt return) give taken_o = 1, cycles_o = 4 and next_pc_o = pc_i, because the real target comes from the stack.
- R7: op_i = 8 skips the next instruction when opnd_a_i equals opnd_b_i.
- R8: op_i = 9 skips the next instruction when opnd_a_i[sel_i] equals pol_i (1 = skip if set, 0 = skip if clear).
- R9: A skip that happens gives taken_o = 1, and next_pc_o = pc_i + 2 with 2 cycles when next_two_word_i = 0, or pc_i + 3 with 3 cycles when it is 1. A skip that does not happen gives pc_i + 1, 1 cycle, taken_o = 0.
- R10: op_i = 0 and the unused codes 10 to 15 are sequential: next_pc_o = pc_i + 1, cycles_o = 1, taken_o = 0.
- R11: The outputs are registered one cycle after the request. out_valid_o follows valid_i one cycle later. A cycle with valid_i = 0 leaves taken_o, next_pc_o and cycles_o unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Request present this cycle |
| op_i | input | 4 | Instruction class code |
| pc_i | input | 16 | Program counter of the current instruction |
| offset_i | input | 12 | Raw signed offset field (low 7 bits used by branches) |
| zptr_i | input | 16 | Z pointer, target of indirect transfers |
| sreg_i | input | 8 | Status byte |
| sel_i | input | 3 | Status bit or data bit selector |
| pol_i | input | 1 | Condition polarity: 1 tests for set, 0 for clear |
| opnd_a_i | input | 8 | First compare operand, or byte under bit test |
| opnd_b_i | input | 8 | Second compare operand |
| next_two_word_i | input | 1 | Following instruction is two words long |
| out_valid_o | output | 1 | Decision valid |
| taken_o | output | 1 | Control flow leaves the sequential path |
| next_pc_o | output | 16 | Program counter to fetch next |
| cycles_o | output | 3 | Cycle cost of the instruction |

## Verification
Assertions check every cycle for properties that depend only on the instruction class. These are the cycle costs of branches, jumps, returns and skips, the not-taken fall-through to pc + 1, the indirect target and return hold, the skip length chosen from the next-word flag, the signed test against N XOR V, and the hold of the outputs across idle cycles. Some results need the full arithmetic, and only the bench's scenarios can show them. These are the exact taken targets with sign-extended 7-bit and 12-bit offsets, the wrap of the program counter, the fact that offset bits above bit 6 have no effect on branches, and every combination of status byte, selector and polarity.

// File: rtl/bsu_pkg.sv
package bsu_pkg;

   typedef enum logic [3:0] {
      OP_SEQ      = 4'd0,
      OP_BRANCH   = 4'd1,
      OP_RJMP     = 4'd2,
      OP_IJMP     = 4'd3,
      OP_RCALL    = 4'd4,
      OP_ICALL    = 4'd5,
      OP_RET      = 4'd6,
      OP_RETI     = 4'd7,
      OP_SKIP_EQ  = 4'd8,
      OP_SKIP_BIT = 4'd9
   } bsu_op_e;

   localparam int SB_N    = 2;
   localparam int SB_V    = 3;
   localparam int SB_SIGN = 4;

endpackage

// File: rtl/bsu_bittest.sv
module bsu_bittest #(
   parameter int W = 8,
   localparam int SW = $clog2(W)
) (
   input  logic [W-1:0]  data_i,
   input  logic [SW-1:0] sel_i,
   input  logic          pol_i,
   output logic          hit_o
);
   assign hit_o = (data_i[sel_i] == pol_i);
endmodule

// File: rtl/bsu_cond.sv
module bsu_cond #(
   parameter bit DERIVE_SIGN = 1'b1
) (
   input  logic [7:0] sreg_i,
   input  logic [2:0] sel_i,
   input  logic       pol_i,
   output logic       hit_o
);
   import bsu_pkg::*;

   logic [7:0] eff_sreg;

   generate
      if (DERIVE_SIGN) begin : g_derive
         // signed condition rebuilt from N and V; the stored copy is overridden
         always_comb begin
            eff_sreg          = sreg_i;
            eff_sreg[SB_SIGN] = sreg_i[SB_N] ^ sreg_i[SB_V];
         end
      end else begin : g_stored
         assign eff_sreg = sreg_i;
      end
   endgenerate

   bsu_bittest #(.W(8)) test_i (
      .data_i (eff_sreg),
      .sel_i  (sel_i),
      .pol_i  (pol_i),
      .hit_o  (hit_o)
   );
endmodule

// File: rtl/bsu_target.sv
module bsu_target #(
   parameter int PC_W      = 16,
   parameter int BR_OFF_W  = 7,
   parameter int JMP_OFF_W = 12,
   parameter int ZP_W      = 16
) (
   input  logic [PC_W-1:0]      pc_i,
   input  logic [JMP_OFF_W-1:0] off_i,
   input  logic                 short_i,
   input  logic [ZP_W-1:0]      zptr_i,
   output logic [PC_W-1:0]      rel_o,
   output logic [PC_W-1:0]      seq_o,
   output logic [PC_W-1:0]      skip1_o,
   output logic [PC_W-1:0]      skip2_o,
   output logic [PC_W-1:0]      ind_o
);
   localparam int BR_PAD  = PC_W - BR_OFF_W;
   localparam int JMP_PAD = PC_W - JMP_OFF_W;

   logic [PC_W-1:0] br_ext;
   logic [PC_W-1:0] jmp_ext;
   logic [PC_W-1:0] sel_ext;

   assign br_ext  = {{BR_PAD{off_i[BR_OFF_W-1]}}, off_i[BR_OFF_W-1:0]};
   assign jmp_ext = {{JMP_PAD{off_i[JMP_OFF_W-1]}}, off_i};
   assign sel_ext = short_i ? br_ext : jmp_ext;

   // one shared adder for both offset sizes
   assign rel_o   = pc_i + sel_ext + PC_W'(1);
   assign seq_o   = pc_i + PC_W'(1);
   assign skip1_o = pc_i + PC_W'(2);
   assign skip2_o = pc_i + PC_W'(3);

   generate
      if (ZP_W >= PC_W) begin : g_zp_trunc
         assign ind_o = zptr_i[PC_W-1:0];
      end else begin : g_zp_ext
         assign ind_o = {{(PC_W-ZP_W){1'b0}}, zptr_i};
      end
   endgenerate
endmodule

// File: rtl/bsu_core.sv
module bsu_core #(
   parameter int PC_W        = 16,
   parameter int BR_OFF_W    = 7,
   parameter int JMP_OFF_W   = 12,
   parameter int ZP_W        = 16,
   parameter int DATA_W      = 8,
   parameter int CYC_W       = 3,
   parameter bit DERIVE_SIGN = 1'b1,
   localparam int SEL_W      = $clog2(DATA_W)
) (
   input  logic                 clk_i,
   input  logic                 rst_ni,
   input  logic                 valid_i,
   input  logic [3:0]           op_i,
   input  logic [PC_W-1:0]      pc_i,
   input  logic [JMP_OFF_W-1:0] offset_i,
   input  logic [ZP_W-1:0]      zptr_i,
   input  logic [7:0]           sreg_i,
   input  logic [SEL_W-1:0]     sel_i,
   input  logic                 pol_i,
   input  logic [DATA_W-1:0]    opnd_a_i,
   input  logic [DATA_W-1:0]    opnd_b_i,
   input  logic                 next_two_word_i,
   output logic                 out_valid_o,
   output logic                 taken_o,
   output logic [PC_W-1:0]      next_pc_o,
   output logic [CYC_W-1:0]     cycles_o
);
   import bsu_pkg::*;

   generate
      if (PC_W <= JMP_OFF_W || JMP_OFF_W <= BR_OFF_W || BR_OFF_W < 2) begin : g_bad_off
         initial $fatal(1, "bsu_core: need PC_W > JMP_OFF_W > BR_OFF_W >= 2");
      end
      if (DATA_W < 8 || (DATA_W & (DATA_W - 1)) != 0) begin : g_bad_data
         initial $fatal(1, "bsu_core: DATA_W must be a power of two of at least 8");
      end
      if (CYC_W < 3) begin : g_bad_cyc
         initial $fatal(1, "bsu_core: CYC_W must hold the value 4");
      end
   endgenerate

   bsu_op_e op;
   assign op = bsu_op_e'(op_i);

   logic status_hit;
   logic bit_hit;
   logic is_short;
   logic [PC_W-1:0] rel_pc, seq_pc, skip1_pc, skip2_pc, ind_pc;

   assign is_short = (op == OP_BRANCH);

   bsu_cond #(.DERIVE_SIGN(DERIVE_SIGN)) cond_i (
      .sreg_i (sreg_i),
      .sel_i  (sel_i[2:0]),
      .pol_i  (pol_i),
      .hit_o  (status_hit)
   );

   bsu_bittest #(.W(DATA_W)) skipbit_i (
      .data_i (opnd_a_i),
      .sel_i  (sel_i),
      .pol_i  (pol_i),
      .hit_o  (bit_hit)
   );

   bsu_target #(
      .PC_W      (PC_W),
      .BR_OFF_W  (BR_OFF_W),
      .JMP_OFF_W (JMP_OFF_W),
      .ZP_W      (ZP_W)
   ) target_i (
      .pc_i    (pc_i),
      .off_i   (offset_i),
      .short_i (is_short),
      .zptr_i  (zptr_i),
      .rel_o   (rel_pc),
      .seq_o   (seq_pc),
      .skip1_o (skip1_pc),
      .skip2_o (skip2_pc),
      .ind_o   (ind_pc)
   );

   logic              do_skip;
   logic              nxt_taken;
   logic [PC_W-1:0]   nxt_pc;
   logic [CYC_W-1:0]  nxt_cyc;

   always_comb begin
      do_skip   = 1'b0;
      nxt_taken = 1'b0;
      nxt_pc    = seq_pc;
      nxt_cyc   = CYC_W'(1);
      unique case (op)
         OP_BRANCH: begin
            if (status_hit) begin
               nxt_taken = 1'b1;
               nxt_pc    = rel_pc;
               nxt_cyc   = CYC_W'(2);
            end
         end
         OP_RJMP, OP_RCALL: begin
            nxt_taken = 1'b1;
            nxt_pc    = rel_pc;
            nxt_cyc   = (op == OP_RCALL) ? CYC_W'(3) : CYC_W'(2);
         end
         OP_IJMP, OP_ICALL: begin
            nxt_taken = 1'b1;
            nxt_pc    = ind_pc;
            nxt_cyc   = (op == OP_ICALL) ? CYC_W'(3) : CYC_W'(2);
         end
         OP_RET, OP_RETI: begin
            nxt_taken = 1'b1;
            nxt_pc    = pc_i;
            nxt_cyc   = CYC_W'(4);
         end
         OP_SKIP_EQ:  do_skip = (opnd_a_i == opnd_b_i);
         OP_SKIP_BIT: do_skip = bit_hit;
         default: ;
      endcase
      if (do_skip) begin
         nxt_taken = 1'b1;
         nxt_pc    = next_two_word_i ? skip2_pc : skip1_pc;
         nxt_cyc   = next_two_word_i ? CYC_W'(3) : CYC_W'(2);
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         out_valid_o <= 1'b0;
         taken_o     <= 1'b0;
         next_pc_o   <= '0;
         cycles_o    <= '0;
      end else begin
         out_valid_o <= valid_i;
         if (valid_i) begin
            taken_o   <= nxt_taken;
            next_pc_o <= nxt_pc;
            cycles_o  <= nxt_cyc;
         end
      end
   end
endmodule

// File: rtl/bsu_chk.sv
module bsu_chk #(
   parameter int PC_W        = 16,
   parameter int ZP_W        = 16,
   parameter int DATA_W      = 8,
   parameter int CYC_W       = 3,
   parameter bit DERIVE_SIGN = 1'b1
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic              valid_i,
   input logic [3:0]        op_i,
   input logic [PC_W-1:0]   pc_i,
   input logic [ZP_W-1:0]   zptr_i,
   input logic              nv_i,
   input logic              sel4_i,
   input logic              pol_i,
   input logic              eq_i,
   input logic              next_two_word_i,
   input logic              out_valid_o,
   input logic              taken_o,
   input logic [PC_W-1:0]   next_pc_o,
   input logic [CYC_W-1:0]  cycles_o
);
   import bsu_pkg::*;

   logic is_seq, is_br, is_jmp, is_ret, is_skip;
   assign is_seq  = (op_i == 4'd0) || (op_i > 4'd9);
   assign is_br   = (op_i == OP_BRANCH);
   assign is_jmp  = (op_i == OP_RJMP) || (op_i == OP_IJMP);
   assign is_ret  = (op_i == OP_RET) || (op_i == OP_RETI);
   assign is_skip = (op_i == OP_SKIP_EQ) || (op_i == OP_SKIP_BIT);

   AST_VALID_LAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
      1'b1 |=> (out_valid_o == $past(valid_i)));                                   // R11
   AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !valid_i |=> ($stable(taken_o) && $stable(next_pc_o) && $stable(cycles_o))); // R11
   AST_SEQ_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_i && is_seq) |=> (!taken_o && cycles_o == CYC_W'(1)
                               && next_pc_o == $past(pc_i) + PC_W'(1)));         // R10
   AST_BRANCH_COST: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_i && is_br) |=> (taken_o ? (cycles_o == CYC_W'(2))
                              : (cycles_o == CYC_W'(1)
                                 && next_pc_o == $past(pc_i) + PC_W'(1))));     // R2
   AST_JUMP_COST: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_i && is_jmp) |=> (taken_o && cycles_o == CYC_W'(2)));               // R4
   AST_IND_TARGET: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_i && (op_i == OP_IJMP || op_i == OP_ICALL))
         |=> (next_pc_o == PC_W'($past(zptr_i))));                                // R5
   AST_RET_COST: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_i && is_ret) |=> (taken_o && cycles_o == CYC_W'(4)
                               && next_pc_o == $past(pc_i)));                     // R6
   AST_EQ_MISS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_i && op_i == OP_SKIP_EQ && !eq_i) |=> (!taken_o && cycles_o == CYC_W'(1))); // R7
   AST_SKIP_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_i && is_skip) |=> (!taken_o
         || cycles_o == ($past(next_two_word_i) ? CYC_W'(3) : CYC_W'(2))));      // R9

   generate
      if (DERIVE_SIGN) begin : g_sign_chk
         AST_SIGNED_TEST: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (valid_i && is_br && sel4_i) |=> (taken_o == ($past(nv_i) == $past(pol_i)))); // R3
      end
   endgenerate
endmodule

bind bsu_core bsu_chk #(
   .PC_W        (PC_W),
   .ZP_W        (ZP_W),
   .DATA_W      (DATA_W),
   .CYC_W       (CYC_W),
   .DERIVE_SIGN (DERIVE_SIGN)
) chk_i (
   .clk_i           (clk_i),
   .rst_ni          (rst_ni),
   .valid_i         (valid_i),
   .op_i            (op_i),
   .pc_i            (pc_i),
   .zptr_i          (zptr_i),
   .nv_i            (sreg_i[2] ^ sreg_i[3]),
   .sel4_i          (sel_i[2:0] == 3'd4),
   .pol_i           (pol_i),
   .eq_i            (opnd_a_i == opnd_b_i),
   .next_two_word_i (next_two_word_i),
   .out_valid_o     (out_valid_o),
   .taken_o         (taken_o),
   .next_pc_o       (next_pc_o),
   .cycles_o        (cycles_o)
);

// File: tb/bsu_core_tb.sv
`timescale 1ns/1ps
module bsu_core_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        valid = 1'b0;
   logic [3:0]  op = '0;
   logic [15:0] pc = '0;
   logic [11:0] off = '0;
   logic [15:0] zp = '0;
   logic [7:0]  sreg = '0;
   logic [2:0]  sel = '0;
   logic        pol = 1'b0;
   logic [7:0]  a = '0;
   logic [7:0]  b = '0;
   logic        two = 1'b0;

   logic        o_valid, o_taken;
   logic [15:0] o_pc;
   logic [2:0]  o_cyc;

   int checks = 0;
   int fails  = 0;
   int seed   = 32'h1234_5678;

   int e_valid = 0, e_taken = 0, e_pc = 0, e_cyc = 0;

   always #2.5 clk = ~clk;

   bsu_core dut_i (
      .clk_i (clk), .rst_ni (rst_n), .valid_i (valid), .op_i (op), .pc_i (pc),
      .offset_i (off), .zptr_i (zp), .sreg_i (sreg), .sel_i (sel), .pol_i (pol),
      .opnd_a_i (a), .opnd_b_i (b), .next_two_word_i (two),
      .out_valid_o (o_valid), .taken_o (o_taken), .next_pc_o (o_pc), .cycles_o (o_cyc)
   );

   function automatic int sx(input int v, input int w);
      int r = v & ((1 << w) - 1);
      if (r >= (1 << (w - 1))) r = r - (1 << w);
      return r;
   endfunction

   function automatic int rnd();
      seed = seed * 1103515245 + 12345;
      return (seed >>> 8) & 32'h00FF_FFFF;
   endfunction

   // behavioural reference, evaluated at each rising edge from the driven inputs
   task automatic model();
      int p = int'(pc);
      int hit;
      int skip = -1;
      if (!valid) begin
         e_valid = 0;
         return;
      end
      e_valid = 1; e_taken = 0; e_pc = (p + 1) & 16'hFFFF; e_cyc = 1;
      case (int'(op))
         1: begin
            hit = (sel == 3'd4) ? int'(sreg[2] ^ sreg[3]) : int'(sreg[sel]);
            if (hit == int'(pol)) begin
               e_taken = 1; e_cyc = 2; e_pc = (p + sx(int'(off), 7) + 1) & 16'hFFFF;
            end
         end
         2, 4: begin
            e_taken = 1; e_cyc = (op == 4'd4) ? 3 : 2;
            e_pc = (p + sx(int'(off), 12) + 1) & 16'hFFFF;
         end
         3, 5: begin
            e_taken = 1; e_cyc = (op == 4'd5) ? 3 : 2; e_pc = int'(zp);
         end
         6, 7: begin
            e_taken = 1; e_cyc = 4; e_pc = p;
         end
         8: skip = (a == b) ? 1 : 0;
         9: skip = (int'(a[sel]) == int'(pol)) ? 1 : 0;
         default: ;
      endcase
      if (skip == 1) begin
         e_taken = 1;
         e_cyc   = two ? 3 : 2;
         e_pc    = (p + (two ? 3 : 2)) & 16'hFFFF;
      end
   endtask

   task automatic compare(input string tag);
      checks++;
      if (int'(o_valid) != e_valid || int'(o_taken) != e_taken ||
          int'(o_pc) != e_pc || int'(o_cyc) != e_cyc) begin
         fails++;
         $display("FAIL %s: op=%0d got v=%0d t=%0d pc=%h cyc=%0d exp v=%0d t=%0d pc=%h cyc=%0d",
                  tag, op, o_valid, o_taken, o_pc, o_cyc, e_valid, e_taken, e_pc[15:0], e_cyc);
      end
   endtask

   task automatic step(input string tag);
      @(posedge clk);
      model();
      @(negedge clk);
      compare(tag);
   endtask

   task automatic finish_run();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   endtask

   initial begin
      #(5.0 * 200000);
      fails++;
      $display("FAIL watchdog: run did not complete, got timeout exp completion");
      finish_run();
   end

   initial begin
      // R1: reset state
      repeat (3) @(negedge clk);
      e_valid = 0; e_taken = 0; e_pc = 0; e_cyc = 0;
      compare("R1");
      rst_n = 1'b1;
      step("R1");

      // R10: sequential and unused codes
      for (int c = 0; c < 16; c++) begin
         if (c != 0 && c < 10) continue;
         valid = 1'b1; op = 4'(c); pc = 16'(rnd()); off = 12'(rnd());
         step("R10");
      end
      pc = 16'hFFFF; op = 4'd0; step("R10");

      // R2 / R3: every status byte, selector and polarity
      op = 4'd1;
      for (int s = 0; s < 8; s++) begin
         for (int pl = 0; pl < 2; pl++) begin
            for (int v = 0; v < 256; v++) begin
               sel = 3'(s); pol = pl[0]; sreg = 8'(v);
               pc = 16'(rnd()); off = 12'(rnd());
               step(s == 4 ? "R3" : "R2");
            end
         end
      end
      // R2: branch offset extremes and wrap, upper offset bits set
      sel = 3'd1; pol = 1'b1; sreg = 8'h02;
      pc = 16'h0000; off = 12'hFC0; step("R2");
      pc = 16'hFFFF; off = 12'h03F; step("R2");
      pc = 16'h1000; off = 12'hF80 | 12'h03F; step("R2");

      // R4: relative jump and call
      foreach (off[i]) ;
      for (int k = 0; k < 8; k++) begin
         int offs [8] = '{0, 1, 12'h7FF, 12'h800, 12'hFFF, 12'h3A5, 12'hC00, 12'h400};
         off = 12'(offs[k]);
         pc = (k < 4) ? 16'hFFF0 : 16'h0008;
         op = 4'd2; step("R4");
         op = 4'd4; step("R4");
      end

      // R5: indirect jump and call
      for (int k = 0; k < 6; k++) begin
         zp = (k == 0) ? 16'h0000 : (k == 1) ? 16'hFFFF : 16'(rnd());
         pc = 16'(rnd());
         op = 4'd3; step("R5");
         op = 4'd5; step("R5");
      end

      // R6: returns
      for (int k = 0; k < 4; k++) begin
         pc = 16'(rnd()); zp = 16'(rnd());
         op = 4'd6; step("R6");
         op = 4'd7; step("R6");
      end

      // R7 / R9: compare-equal skip, both next-word lengths
      op = 4'd8;
      for (int k = 0; k < 40; k++) begin
         a = 8'(rnd()); b = (k % 2 == 0) ? a : 8'(rnd());
         two = k[1]; pc = (k < 4) ? 16'hFFFE : 16'(rnd());
         step("R7,R9");
      end

      // R8 / R9: bit skip over every bit, polarity and length
      op = 4'd9;
      for (int s = 0; s < 8; s++) begin
         for (int pl = 0; pl < 2; pl++) begin
            for (int t = 0; t < 2; t++) begin
               for (int k = 0; k < 4; k++) begin
                  sel = 3'(s); pol = pl[0]; two = t[0];
                  a = 8'(rnd()); pc = 16'(rnd());
                  step("R8,R9");
               end
            end
         end
      end

      // R11: idle cycles hold results despite changing inputs
      op = 4'd2; pc = 16'h2222; off = 12'h010; valid = 1'b1; step("R11");
      valid = 1'b0;
      for (int k = 0; k < 6; k++) begin
         op = 4'(k + 1); pc = 16'(rnd()); off = 12'(rnd()); zp = 16'(rnd());
         step("R11");
      end
      valid = 1'b1; op = 4'd6; pc = 16'h0ABC; step("R11");
      valid = 1'b0; step("R11");

      finish_run();
   end
endmodule